// File: doc/BRIEF.md
# AES Column Mixing Unit

This block applies the AES column-mixing step to one 32-bit state column (four bytes). It works for both directions. A mode input selects the direction. In forward mode the column is multiplied over GF(2^8) by the circulant matrix whose first row is 02 03 01 01. In inverse mode it is multiplied by the circulant matrix whose first row is 0E 0B 0D 09. A full 128-bit state is handled in one of two ways: four instances side by side, or four passes through one instance.

The forward path uses only doubling logic, which is a left shift with a conditional reduction XOR. The inverse path sends its four coefficients through a general GF(2^8) multiplier. That multiplier forms AND partial products, sums them with XOR, and then folds the upper bits back with the reduction polynomial. The result is registered. A valid flag goes with the result, one clock behind the input strobe.

Top module: `col_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `col_out` = 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. Back-to-back strobes give back-to-back results, each one for its own input.
- R3: With `inv_mode` = 0, output byte i is the XOR of the products of the input bytes with matrix row i. The rows are 02 03 01 01, 01 02 03 01, 01 01 02 03 and 03 01 01 02. Byte 0 is `col_in[31:24]` / `col_out[31:24]` and byte 3 is bits [7:0]. Example: db135345 gives 8e4da1bc.
- R4: Doubling a byte with its top bit set reduces by XOR with 0x1B. For example, the forward result of column 80000000 is 1b80809b.
- R5: With `inv_mode` = 1, the rows used are 0E 0B 0D 09, 09 0E 0B 0D, 0D 09 0E 0B and 0B 0D 09 0E. Example: 8e4da1bc gives db135345.
- R6: Applying the forward transform and then the inverse transform to any column returns the original column.
- R7: In a cycle after `in_valid` was low, `col_out` keeps its previous value, whatever `col_in` and `inv_mode` were.
- R8: A column whose four bytes are equal maps to itself in both modes.
- R9: The transform is linear over XOR: the result for a^b equals the result for a XORed with the result for b, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input column strobe |
| inv_mode | input | 1 | 0 = forward mixing, 1 = inverse mixing |
| col_in | input | 32 | Input column, byte 0 in bits [31:24] |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| col_out | output | 32 | Registered mixed column |

## Verification
The bench builds the block with its default 8-bit field width and the 0x1B reduction polynomial. That is the only setting for which published AES column vectors exist. With it, the known forward and inverse vectors and the 0x80 reduction case can be checked. Random columns are pushed through forward and then inverse mode to test the round trip, and random pairs are used to test XOR linearity. The bench also compares every result against its own model, which is a table-free shift-and-add multiplier.

// File: rtl/col_mixer_pkg.sv
// Package: shared widths, reduction polynomial and coefficient tables for
// the column mixer. Assumes a four-byte column and an 8-bit field.
package col_mixer_pkg;
    localparam int GF_W    = 8;
    localparam int LANES   = 4;
    localparam int COL_W   = GF_W * LANES;
    localparam logic [GF_W-1:0] GF_POLY = 8'h1B;

    typedef logic [GF_W-1:0] gf_t;

    // Doubling in the field: shift left, fold the carried-out bit back.
    function automatic gf_t gf_dbl(input gf_t v);
        return {v[GF_W-2:0], 1'b0} ^ (v[GF_W-1] ? GF_POLY : '0);
    endfunction

    // First row of the inverse matrix; later rows rotate it right.
    function automatic gf_t inv_coef(input int idx);
        case (idx)
            0:       return 8'h0E;
            1:       return 8'h0B;
            2:       return 8'h0D;
            default: return 8'h09;
        endcase
    endfunction
endpackage

// File: rtl/gf_mul_general.sv
// General GF(2^W) multiplier: AND partial products summed by XOR, then the
// double-width product is reduced by the package polynomial. Purely
// combinational; assumes W >= 2.
module gf_mul_general
    import col_mixer_pkg::*;
(
    input  logic [GF_W-1:0] op_a,
    input  logic [GF_W-1:0] op_b,
    output logic [GF_W-1:0] prod
);
    localparam int WIDE = 2 * GF_W - 1;

    logic [WIDE-1:0] raw;
    logic [WIDE-1:0] red;

    // Carry-less product of the two operands.
    always_comb begin
        raw = '0;
        for (int i = 0; i < GF_W; i++) begin
            if (op_b[i]) raw = raw ^ (WIDE'(op_a) << i);
        end
    end

    // Fold bits above the field width down, highest bit first.
    always_comb begin
        red = raw;
        for (int k = WIDE - 1; k >= GF_W; k--) begin
            if (red[k]) red = red ^ (WIDE'({1'b1, GF_POLY}) << (k - GF_W));
        end
    end

    assign prod = red[GF_W-1:0];
endmodule

// File: rtl/mix_fwd_column.sv
// Forward column mixing with doubling logic only: coefficient 03 is formed
// as the doubled byte XOR the byte itself. Combinational.
module mix_fwd_column
    import col_mixer_pkg::*;
(
    input  logic [COL_W-1:0] col,
    output logic [COL_W-1:0] mixed
);
    gf_t b  [LANES];
    gf_t b2 [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Split the column (byte 0 on top) and double every byte.
            assign b[g]  = col[COL_W-1-GF_W*g -: GF_W];
            assign b2[g] = gf_dbl(b[g]);
            // Row g: 02 on byte g, 03 on g+1, 01 on g+2 and g+3.
            assign mixed[COL_W-1-GF_W*g -: GF_W] =
                b2[g] ^ b2[(g+1)%LANES] ^ b[(g+1)%LANES]
                      ^ b[(g+2)%LANES] ^ b[(g+3)%LANES];
        end
    endgenerate
endmodule

// File: rtl/mix_inv_column.sv
// Inverse column mixing: each of the sixteen coefficient products goes
// through a general field multiplier; rows rotate the 0E 0B 0D 09 pattern.
module mix_inv_column
    import col_mixer_pkg::*;
(
    input  logic [COL_W-1:0] col,
    output logic [COL_W-1:0] mixed
);
    gf_t b [LANES];
    gf_t p [LANES][LANES];

    genvar r, c;
    generate
        for (c = 0; c < LANES; c++) begin : g_split
            assign b[c] = col[COL_W-1-GF_W*c -: GF_W];
        end
        for (r = 0; r < LANES; r++) begin : g_row
            for (c = 0; c < LANES; c++) begin : g_col
                gf_mul_general u_mul (
                    .op_a (b[c]),
                    .op_b (inv_coef((c - r + LANES) % LANES)),
                    .prod (p[r][c])
                );
            end
            // Sum the row's products.
            assign mixed[COL_W-1-GF_W*r -: GF_W] =
                p[r][0] ^ p[r][1] ^ p[r][2] ^ p[r][3];
        end
    endgenerate
endmodule

// File: rtl/col_mixer.sv
// Top: selects forward or inverse mixing and registers the result with a
// valid flag one clock behind the input strobe. The result register only
// loads on a strobe. Synchronous active-low reset.
module col_mixer
    import col_mixer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             inv_mode,
    input  logic [COL_W-1:0] col_in,
    output logic             out_valid,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] fwd_res;
    logic [COL_W-1:0] inv_res;

    mix_fwd_column u_fwd (.col(col_in), .mixed(fwd_res));
    mix_inv_column u_inv (.col(col_in), .mixed(inv_res));

    // Register the chosen result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            col_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) col_out <= inv_mode ? inv_res : fwd_res;
        end
    end
endmodule

// File: rtl/col_mixer_chk.sv
// Checker for col_mixer: timing of the valid flag, hold behaviour, reset
// values and the fixed point of uniform columns. Bound below.
module col_mixer_chk
    import col_mixer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             inv_mode,
    input logic [COL_W-1:0] col_in,
    input logic             out_valid,
    input logic [COL_W-1:0] col_out
);
    logic uniform;
    assign uniform = (col_in[31:24] == col_in[23:16]) &&
                     (col_in[23:16] == col_in[15:8]) &&
                     (col_in[15:8]  == col_in[7:0]);

    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && col_out == '0));
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col_out));
    assert_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && uniform) |=> col_out == $past(col_in));

    logic unused_mode;
    assign unused_mode = inv_mode;
endmodule

bind col_mixer col_mixer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
    .col_in(col_in), .out_valid(out_valid), .col_out(col_out)
);

// File: tb/col_mixer_tb_top.sv
`timescale 1ns/1ps
module col_mixer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        inv_mode = 1'b0;
    logic [31:0] col_in = '0;
    logic        out_valid;
    logic [31:0] col_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    col_mixer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
        .col_in(col_in), .out_valid(out_valid), .col_out(col_out)
    );

    // Reference field product, shift-and-add form.
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[0]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
            b = b >> 1;
        end
        return p;
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c, input bit inv);
        logic [7:0] fr [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] ir [4] = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        logic [31:0] r = 0;
        for (int row = 0; row < 4; row++) begin
            logic [7:0] acc = 0;
            for (int k = 0; k < 4; k++)
                acc ^= ref_mul(c[31-8*k -: 8], inv ? ir[(k-row+4)%4] : fr[(k-row+4)%4]);
            r[31-8*row -: 8] = acc;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One strobe; returns the registered result seen one clock later.
    task automatic run(input logic [31:0] c, input bit inv, output logic [31:0] res);
        @(negedge clk);
        col_in = c; inv_mode = inv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid after strobe", {31'b0, out_valid}, 32'd1);
        res = col_out;
    endtask

    task automatic t_reset();
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 col_out", col_out, 32'd0);
    endtask

    task automatic t_known();
        logic [31:0] r;
        run(32'hdb135345, 0, r); check("R3 db135345", r, 32'h8e4da1bc);
        run(32'hd4d4d4d5, 0, r); check("R3 d4d4d4d5", r, 32'hd5d5d7d6);
        run(32'h2d26314c, 0, r); check("R3 2d26314c", r, 32'h4d7ebdf8);
        run(32'h80000000, 0, r); check("R4 reduction", r, 32'h1b80809b);
        run(32'h00ff0000, 0, r); check("R4 ff byte", r, ref_mix(32'h00ff0000, 0));
        run(32'h8e4da1bc, 1, r); check("R5 8e4da1bc", r, 32'hdb135345);
        run(32'h4d7ebdf8, 1, r); check("R5 4d7ebdf8", r, 32'h2d26314c);
    endtask

    task automatic t_roundtrip();
        logic [31:0] f, b, x;
        for (int i = 0; i < 40; i++) begin
            x = $urandom;
            run(x, 0, f); check("R3 model", f, ref_mix(x, 0));
            run(f, 1, b); check("R6 round trip", b, x);
        end
    endtask

    task automatic t_hold();
        logic [31:0] r, keep;
        run(32'h01234567, 1, keep);
        @(negedge clk);
        col_in = 32'hffffffff; inv_mode = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R7 hold", col_out, keep);
        check("R7 valid low", {31'b0, out_valid}, 32'd0);
        r = keep;
        check("R5 model", r, ref_mix(32'h01234567, 1));
    endtask

    task automatic t_uniform();
        logic [31:0] r;
        run(32'hc6c6c6c6, 0, r); check("R8 fwd", r, 32'hc6c6c6c6);
        run(32'h9d9d9d9d, 1, r); check("R8 inv", r, 32'h9d9d9d9d);
    endtask

    task automatic t_linear();
        logic [31:0] a, b, ra, rb, rab;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 6; i++) begin
                a = $urandom; b = $urandom;
                run(a, m[0], ra); run(b, m[0], rb); run(a ^ b, m[0], rab);
                check("R9 linear", rab, ra ^ rb);
            end
        end
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        col_in = 32'hdb135345; inv_mode = 0; in_valid = 1;
        @(negedge clk);
        check("R2 first", col_out, 32'h8e4da1bc);
        col_in = 32'h8e4da1bc; inv_mode = 1;
        @(negedge clk);
        check("R2 second", col_out, 32'hdb135345);
        check("R2 valid kept", {31'b0, out_valid}, 32'd1);
        in_valid = 0;
        @(negedge clk);
        check("R2 valid drop", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_known();
        t_roundtrip();
        t_hold();
        t_uniform();
        t_linear();
        t_back_to_back();
        finish_run();
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule